// File: doc/BRIEF.md
# Tagged-FIFO Eight-Channel Write DMA

This block empties a small shared input queue whose entries each carry a 3-bit channel tag. Every entry is written to memory by the DMA engine of the channel it is tagged for. Each of the eight engines holds two base indices that it can use in turn (buffer A and buffer B), a signed address step and a transfer count. Software programs the engines and the enables through a simple register port. A capture front end pushes tagged words into the queue. The block issues one single-beat memory write per cycle, held until the memory accepts it.

Software can pause the engines without losing queued data, or drop the whole port, which empties the queue. Data that arrives for a channel that has already finished is thrown away, so it cannot block the channels that are still running. A word that arrives while the queue is full is lost. A sticky flag records the loss against the tag of the lost word.

Top module: `mcfifo_dma`

## Requirements
- R1: After reset `mem_valid` is low, and the control, status and all channel parameter registers read 0.
- R2: The control register is at address 0x00: bit 0 is the port enable, bit 1 the DMA enable, bits 15:8 the per-channel enables and bits 23:16 the per-channel buffer-alternation modes. Channel c's parameters are at 0x10+4c+k, with k=0 buffer A index, k=1 buffer B index, k=2 signed step and k=3 count. All of them read back as written.
- R3: Writing a channel's count arms it: its current index becomes buffer A and its remaining count becomes the written value. Each memory write goes to the current index, carries the low 32 bits of the entry, and then moves the index by the signed step. Entries are written in queue order.
- R4: With alternation off, a channel finishes after `count` writes. Its busy bit then clears while both enables stay set.
- R5: With alternation on, when the remaining count reaches zero the count is reloaded and the index restarts at the other buffer's base. The channel never finishes.
- R6: The status register is at 0x01, with busy bits at 7:0. A busy bit sets when the DMA enable, the channel enable and an armed, unfinished channel coincide, even with no data queued. A channel whose four parameter registers are all zero reads 0.
- R7: While the DMA enable is 0, no memory write occurs and queued entries are kept. Setting the enable again resumes the writes in order, at the interrupted addresses.
- R8: While the port enable is 0, the queue is emptied and pushes are ignored. After the port is enabled again, new entries are accepted and written.
- R9: While the port and DMA are enabled, a head entry tagged for a finished channel is popped without a memory write.
- R10: A push while the queue is full drops the word and sets overflow bit `8+tag` of the status register.
- R11: Overflow bits are sticky. Writing 1 to a bit clears it, and clearing the port enable clears all of them.
- R12: While `mem_ready` is low, the offered write (`mem_valid`, `mem_addr`) stays put and the queue does not shrink. At most one entry leaves the queue per cycle.
- R13: The queue holds exactly 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| in_valid | input | 1 | Push a tagged word into the queue |
| in_tag | input | 3 | Channel tag of the pushed word |
| in_data | input | 32 | Pushed word |
| mem_valid | output | 1 | Memory write offered |
| mem_addr | output | 32 | Memory write index |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the offered write |

## Verification
Several properties are checked on every cycle. The queue never holds more than eight entries and is empty the cycle after the port is disabled. Its level never drops by more than one per cycle, and it never drops while an offered write is stalled. Overflow bits are only lost through a clear or a port disable, and no channel is busy and finished at once. Only the bench's scenarios can show the address sequences: the signed step, the alternation between buffers and completion after the count. The same holds for discarding data for finished channels, resuming after a pause without loss, and which overflow bit a lost word sets.

// File: rtl/mcd_pkg.sv
// Shared register map and parameter-slot encoding for the tagged-FIFO DMA.
// Assumes at most eight channels so that every per-channel field fits in a byte.
package mcd_pkg;
    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] ADDR_CTRL    = 6'h00;
    localparam logic [REG_AW-1:0] ADDR_STAT    = 6'h01;
    localparam logic [REG_AW-1:0] ADDR_CH_BASE = 6'h10;

    localparam int CTL_PORT_BIT  = 0;
    localparam int CTL_DMA_BIT   = 1;
    localparam int CTL_CHEN_LSB  = 8;
    localparam int CTL_ALT_LSB   = 16;
    localparam int STAT_BUSY_LSB = 0;
    localparam int STAT_OVF_LSB  = 8;
    localparam int MAX_CH        = 8;

    typedef enum logic [1:0] {
        PRM_BASE_A = 2'd0,
        PRM_BASE_B = 2'd1,
        PRM_STEP   = 2'd2,
        PRM_COUNT  = 2'd3
    } prm_sel_e;
endpackage

// File: rtl/mcd_fifo.sv
// Tagged word queue: circular buffer with a level counter and a synchronous flush.
// Assumes the caller never pushes when full nor pops when empty.
module mcd_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed word in the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= wdata;
    end

    // Advance pointers and level; a flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    assign rdata = slots[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
endmodule

// File: rtl/mcd_regs.sv
// Register file: control, status with sticky write-1-to-clear overflow bits, and
// four parameter slots per channel. A count write also emits a one-cycle arm pulse.
// Assumes NCH <= 8 and AW, CNTW <= RW.
module mcd_regs
    import mcd_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 32,
    parameter int CNTW = 16,
    parameter int RW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [RW-1:0]        reg_wdata,
    output logic [RW-1:0]        reg_rdata,
    input  logic [NCH-1:0]       busy,
    input  logic [NCH-1:0]       ovf_set,
    output logic                 port_en,
    output logic                 dma_en,
    output logic [NCH-1:0]       ch_en,
    output logic [NCH-1:0]       alt_en,
    output logic [AW-1:0]        base_a [NCH],
    output logic [AW-1:0]        base_b [NCH],
    output logic [AW-1:0]        step   [NCH],
    output logic [CNTW-1:0]      count  [NCH],
    output logic [NCH-1:0]       arm,
    output logic [NCH-1:0]       ovf,
    output logic                 stat_wr
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [REG_AW-1:0] off;
    logic              ch_hit;
    logic [CHW-1:0]    ch_sel;
    prm_sel_e          prm;
    logic              ctrl_wr;
    logic [NCH-1:0]    w1c_mask;

    assign off      = reg_addr - ADDR_CH_BASE;
    assign ch_hit   = (reg_addr >= ADDR_CH_BASE) && (off < REG_AW'(4 * NCH));
    assign ch_sel   = off[2 +: CHW];
    assign prm      = prm_sel_e'(off[1:0]);
    assign ctrl_wr  = reg_we && (reg_addr == ADDR_CTRL);
    assign stat_wr  = reg_we && (reg_addr == ADDR_STAT);
    assign w1c_mask = stat_wr ? reg_wdata[STAT_OVF_LSB +: NCH] : '0;

    // Capture the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en <= 1'b0;
            dma_en  <= 1'b0;
            ch_en   <= '0;
            alt_en  <= '0;
        end else if (ctrl_wr) begin
            port_en <= reg_wdata[CTL_PORT_BIT];
            dma_en  <= reg_wdata[CTL_DMA_BIT];
            ch_en   <= reg_wdata[CTL_CHEN_LSB +: NCH];
            alt_en  <= reg_wdata[CTL_ALT_LSB +: NCH];
        end
    end

    // Sticky overflow flags: set by lost words, cleared by W1C or port disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en) ovf <= '0;
        else                    ovf <= (ovf & ~w1c_mask) | ovf_set;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_prm
        logic            hit;
        logic [AW-1:0]   r_base_a;
        logic [AW-1:0]   r_base_b;
        logic [AW-1:0]   r_step;
        logic [CNTW-1:0] r_count;

        assign hit    = reg_we && ch_hit && (ch_sel == CHW'(c));
        assign arm[c] = hit && (prm == PRM_COUNT);

        // Hold this channel's four parameter slots.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_base_a <= '0;
                r_base_b <= '0;
                r_step   <= '0;
                r_count  <= '0;
            end else if (hit) begin
                case (prm)
                    PRM_BASE_A: r_base_a <= reg_wdata[AW-1:0];
                    PRM_BASE_B: r_base_b <= reg_wdata[AW-1:0];
                    PRM_STEP:   r_step   <= reg_wdata[AW-1:0];
                    PRM_COUNT:  r_count  <= reg_wdata[CNTW-1:0];
                    default:    r_count  <= r_count;
                endcase
            end
        end

        assign base_a[c] = r_base_a;
        assign base_b[c] = r_base_b;
        assign step[c]   = r_step;
        assign count[c]  = r_count;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTL_PORT_BIT]         = port_en;
            reg_rdata[CTL_DMA_BIT]          = dma_en;
            reg_rdata[CTL_CHEN_LSB +: NCH]  = ch_en;
            reg_rdata[CTL_ALT_LSB +: NCH]   = alt_en;
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata[STAT_BUSY_LSB +: NCH] = busy;
            reg_rdata[STAT_OVF_LSB +: NCH]  = ovf;
        end else if (ch_hit) begin
            case (prm)
                PRM_BASE_A: reg_rdata = RW'(base_a[ch_sel]);
                PRM_BASE_B: reg_rdata = RW'(base_b[ch_sel]);
                PRM_STEP:   reg_rdata = RW'(step[ch_sel]);
                default:    reg_rdata = RW'(count[ch_sel]);
            endcase
        end
    end
endmodule

// File: rtl/mcd_chan.sv
// One DMA engine: current index, remaining count, buffer selector, finished flag
// and busy status. Arming loads buffer A and the count supplied with the arm pulse.
// Assumes at most one transfer per cycle, signalled by xfer.
module mcd_chan #(
    parameter int AW   = 32,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   cfg_base_a,
    input  logic [AW-1:0]   cfg_base_b,
    input  logic [AW-1:0]   cfg_step,
    input  logic [CNTW-1:0] cfg_count,
    input  logic            alt_en,
    input  logic            ch_en,
    input  logic            dma_en,
    input  logic            arm,
    input  logic [CNTW-1:0] arm_count,
    input  logic            xfer,
    output logic [AW-1:0]   cur_addr,
    output logic            done,
    output logic            busy
);
    logic [CNTW-1:0] remain;
    logic            on_b;
    logic            used;
    logic            last;
    logic            reload;
    logic            finish;

    assign used   = |{cfg_base_a, cfg_base_b, cfg_step, cfg_count};
    assign last   = (remain == CNTW'(1));
    assign reload = alt_en && (cfg_count != '0);
    assign finish = xfer && last && !reload;

    // Walk the index and count; swap buffers or finish at the end of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            on_b     <= 1'b0;
            done     <= 1'b1;
        end else if (arm) begin
            cur_addr <= cfg_base_a;
            remain   <= arm_count;
            on_b     <= 1'b0;
            done     <= (arm_count == '0);
        end else if (xfer) begin
            if (last && reload) begin
                remain   <= cfg_count;
                on_b     <= ~on_b;
                cur_addr <= on_b ? cfg_base_a : cfg_base_b;
            end else begin
                remain   <= remain - 1'b1;
                cur_addr <= cur_addr + cfg_step;
                if (last) done <= 1'b1;
            end
        end
    end

    // Busy status: raised by the enables, dropped on finish, re-arm or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                          busy <= 1'b0;
        else if (arm || !ch_en || finish)    busy <= 1'b0;
        else if (dma_en && !done && used)    busy <= 1'b1;
    end
endmodule

// File: rtl/mcfifo_dma.sv
// Top: tagged input queue drained into per-channel DMA engines through a single
// memory write port. The head entry is offered combinationally; it leaves the
// queue on acceptance, or at once when its channel has finished.
// Assumes NCH <= 8 and a memory that may hold mem_ready low for any time.
module mcfifo_dma
    import mcd_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CNTW       = 16,
    parameter int RW         = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic [RW-1:0]                reg_wdata,
    output logic [RW-1:0]                reg_rdata,
    input  logic                         in_valid,
    input  logic [$clog2(NCH)-1:0]       in_tag,
    input  logic [DW-1:0]                in_data,
    output logic                         mem_valid,
    output logic [AW-1:0]                mem_addr,
    output logic [DW-1:0]                mem_wdata,
    input  logic                         mem_ready
);
    localparam int CHW = $clog2(NCH);
    localparam int EW  = CHW + DW;
    localparam int LW  = $clog2(FIFO_DEPTH + 1);

    logic              port_en;
    logic              dma_en;
    logic [NCH-1:0]    ch_en;
    logic [NCH-1:0]    alt_en;
    logic [AW-1:0]     base_a [NCH];
    logic [AW-1:0]     base_b [NCH];
    logic [AW-1:0]     step   [NCH];
    logic [CNTW-1:0]   count  [NCH];
    logic [NCH-1:0]    arm;
    logic [NCH-1:0]    ovf;
    logic [NCH-1:0]    ovf_set;
    logic              stat_wr;
    logic [NCH-1:0]    ch_busy;
    logic [NCH-1:0]    ch_done;
    logic [NCH-1:0]    xfer;
    logic [AW-1:0]     cur_addr [NCH];

    logic [EW-1:0]     head;
    logic [CHW-1:0]    head_tag;
    logic              fifo_empty;
    logic              fifo_full;
    logic [LW-1:0]     fifo_level;
    logic              push;
    logic              pop;
    logic              run;
    logic              discard;
    logic              accept;

    mcd_regs #(.NCH(NCH), .AW(AW), .CNTW(CNTW), .RW(RW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy     (ch_busy),
        .ovf_set  (ovf_set),
        .port_en  (port_en),
        .dma_en   (dma_en),
        .ch_en    (ch_en),
        .alt_en   (alt_en),
        .base_a   (base_a),
        .base_b   (base_b),
        .step     (step),
        .count    (count),
        .arm      (arm),
        .ovf      (ovf),
        .stat_wr  (stat_wr)
    );

    // Input side: accept while enabled and not full; a word hitting a full queue is lost.
    assign push    = in_valid && port_en && !fifo_full;
    assign ovf_set = (in_valid && port_en && fifo_full) ? (NCH'(1) << in_tag) : '0;

    mcd_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(!port_en),
        .push (push),
        .pop  (pop),
        .wdata({in_tag, in_data}),
        .rdata(head),
        .empty(fifo_empty),
        .full (fifo_full),
        .level(fifo_level)
    );

    // Head dispatch: offer a write, or drop an entry whose channel has finished.
    assign head_tag  = head[DW +: CHW];
    assign run       = port_en && dma_en && !fifo_empty;
    assign discard   = run && ch_done[head_tag];
    assign mem_valid = run && !ch_done[head_tag] && ch_en[head_tag];
    assign accept    = mem_valid && mem_ready;
    assign pop       = discard || accept;
    assign mem_addr  = cur_addr[head_tag];
    assign mem_wdata = head[DW-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign xfer[c] = accept && (head_tag == CHW'(c));

        mcd_chan #(.AW(AW), .CNTW(CNTW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_base_a(base_a[c]),
            .cfg_base_b(base_b[c]),
            .cfg_step  (step[c]),
            .cfg_count (count[c]),
            .alt_en    (alt_en[c]),
            .ch_en     (ch_en[c]),
            .dma_en    (dma_en),
            .arm       (arm[c]),
            .arm_count (reg_wdata[CNTW-1:0]),
            .xfer      (xfer[c]),
            .cur_addr  (cur_addr[c]),
            .done      (ch_done[c]),
            .busy      (ch_busy[c])
        );
    end
endmodule

// File: rtl/mcd_chk.sv
// Cycle-level properties of the tagged-FIFO DMA, attached to the top by bind.
module mcd_chk #(
    parameter int NCH   = 8,
    parameter int DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        port_en,
    input logic                        stat_wr,
    input logic                        mem_valid,
    input logic                        mem_ready,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_level,
    input logic [NCH-1:0]              busy,
    input logic [NCH-1:0]              done,
    input logic [NCH-1:0]              ovf
);
    // R13: the queue never holds more than its depth
    a_r13_depth: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= DEPTH);

    // R8: a disabled port leaves the queue empty on the next cycle
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> fifo_level == '0);

    // R12: a stalled write does not shrink the queue
    a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && port_en) |=> int'(fifo_level) >= int'($past(fifo_level)));

    // R12: at most one entry leaves per cycle
    a_r12_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> int'(fifo_level) + 1 >= int'($past(fifo_level)));

    // R11: overflow bits are lost only through a clear write or a port disable
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !stat_wr) |=> (($past(ovf) & ~ovf) == '0));

    // R4: a finished channel is never reported busy
    a_r4_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & done) == '0);
endmodule

bind mcfifo_dma mcd_chk #(.NCH(NCH), .DEPTH(FIFO_DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .stat_wr   (stat_wr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .fifo_level(fifo_level),
    .busy      (ch_busy),
    .done      (ch_done),
    .ovf       (ovf)
);

// File: tb/test_mcfifo_dma.sv
`timescale 1ns/1ps
module test_mcfifo_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [2:0]  in_tag = '0;
    logic [31:0] in_data = '0;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int nlog  = 0;
    logic [31:0] log_a [64];
    logic [31:0] log_d [64];

    localparam logic [31:0] CTRL_RUN   = 32'h0002_1F03;
    localparam logic [31:0] CTRL_PAUSE = 32'h0002_1F01;
    localparam logic [31:0] CTRL_NOPRT = 32'h0002_1F02;

    typedef struct packed {
        logic [2:0]  tag;
        logic [15:0] dat;
        logic [31:0] adr;
    } vec_t;

    // ch0 base 0x100 step 4 count 3; ch1 A 0x200 B 0x300 step 1 count 2 alternating;
    // ch2 base 0x400 step -8 count 2
    localparam vec_t VEC [10] = '{
        '{3'd0, 16'hA000, 32'h0000_0100},
        '{3'd1, 16'hA001, 32'h0000_0200},
        '{3'd2, 16'hA002, 32'h0000_0400},
        '{3'd0, 16'hA003, 32'h0000_0104},
        '{3'd1, 16'hA004, 32'h0000_0201},
        '{3'd1, 16'hA005, 32'h0000_0300},
        '{3'd2, 16'hA006, 32'h0000_03F8},
        '{3'd0, 16'hA007, 32'h0000_0108},
        '{3'd1, 16'hA008, 32'h0000_0301},
        '{3'd1, 16'hA009, 32'h0000_0200}
    };

    mcfifo_dma i_mcfifo_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .in_valid (in_valid),
        .in_tag   (in_tag),
        .in_data  (in_data),
        .mem_valid(mem_valid),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ready(mem_ready)
    );

    always #2.5 clk = ~clk;

    // Record every write that will be accepted at the coming edge.
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && nlog < 64) begin
            log_a[nlog] = mem_addr;
            log_d[nlog] = mem_wdata;
            nlog++;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] pa(input int ch, input int k);
        return 6'(16 + 4 * ch + k);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic push(input logic [2:0] t, input logic [31:0] d);
        @(posedge clk); #1;
        in_valid = 1'b1; in_tag = t; in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic set_ready(input logic r);
        @(posedge clk); #1;
        mem_ready = r;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int n0;
        cyc(3); #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 mem_valid", 32'(mem_valid), 32'h0);
        rd(6'h00, rv);    chk("R1 control", rv, 32'h0);
        rd(6'h01, rv);    chk("R1 status", rv, 32'h0);
        rd(pa(5, 3), rv); chk("R1 count", rv, 32'h0);

        // program channels (count last: it arms)
        wr(pa(0, 0), 32'h100); wr(pa(0, 2), 32'd4); wr(pa(0, 3), 32'd3);
        wr(pa(1, 0), 32'h200); wr(pa(1, 1), 32'h300); wr(pa(1, 2), 32'd1); wr(pa(1, 3), 32'd2);
        wr(pa(2, 0), 32'h400); wr(pa(2, 2), 32'hFFFF_FFF8); wr(pa(2, 3), 32'd2);
        wr(pa(4, 0), 32'h500); wr(pa(4, 2), 32'd1); wr(pa(4, 3), 32'd5);
        wr(6'h00, CTRL_RUN);
        rd(pa(1, 1), rv); chk("R2 buffer B readback", rv, 32'h300);
        rd(pa(2, 2), rv); chk("R2 step readback", rv, 32'hFFFF_FFF8);
        rd(6'h00, rv);    chk("R2 control readback", rv, CTRL_RUN);

        // R3/R5: vector table, one entry per row
        for (int i = 0; i < 10; i++) begin
            push(VEC[i].tag, {16'h0, VEC[i].dat});
            cyc(3);
            chk("R3/R5 address", log_a[i], VEC[i].adr);
            chk("R3 data", log_d[i], {16'h0, VEC[i].dat});
        end
        chk("R3 write count", 32'(nlog), 32'd10);

        // R4, R6: ch0/ch2 finished, ch1 alternating, ch4 armed without data, ch3 unused
        rd(6'h01, rv); chk("R4/R6 busy bits", rv, 32'h0000_0012);

        // R9: entry for finished ch0 is dropped; ch1 continues at 0x201
        n0 = nlog;
        push(3'd0, 32'hB000);
        push(3'd1, 32'hB001);
        cyc(3);
        chk("R9 writes after discard", 32'(nlog - n0), 32'd1);
        chk("R9 next address", log_a[n0], 32'h201);

        // R7: pause keeps entries, resume drains them in order
        wr(6'h00, CTRL_PAUSE);
        n0 = nlog;
        push(3'd1, 32'hC000); push(3'd1, 32'hC001); push(3'd1, 32'hC002);
        cyc(4);
        chk("R7 no write while paused", 32'(nlog - n0), 32'd0);
        wr(6'h00, CTRL_RUN);
        cyc(6);
        chk("R7 writes after resume", 32'(nlog - n0), 32'd3);
        chk("R7 resume addr 0", log_a[n0],     32'h300);
        chk("R7 resume addr 1", log_a[n0 + 1], 32'h301);
        chk("R7 resume addr 2", log_a[n0 + 2], 32'h200);
        chk("R7 resume data 2", log_d[n0 + 2], 32'hC002);

        // R12: stalled write is held
        set_ready(1'b0);
        n0 = nlog;
        push(3'd1, 32'hD000);
        cyc(3);
        @(negedge clk);
        chk("R12 valid held", 32'(mem_valid), 32'h1);
        chk("R12 address held", mem_addr, 32'h201);
        chk("R12 no write while stalled", 32'(nlog - n0), 32'd0);
        set_ready(1'b1);
        cyc(3);
        chk("R12 write after ready", log_d[n0], 32'hD000);

        // R10, R13: fill eight, ninth word (tag 5) is lost
        set_ready(1'b0);
        n0 = nlog;
        for (int i = 0; i < 8; i++) push(3'd1, 32'hF000 + 32'(i));
        push(3'd5, 32'hF0FF);
        cyc(2);
        rd(6'h01, rv); chk("R10 overflow bit tag5", rv, 32'h0000_2012);
        set_ready(1'b1);
        cyc(14);
        chk("R13 eight entries kept", 32'(nlog - n0), 32'd8);
        chk("R13 last kept word", log_d[n0 + 7], 32'hF007);

        // R11: sticky until write-1-to-clear
        rd(6'h01, rv); chk("R11 sticky after drain", rv, 32'h0000_2012);
        wr(6'h01, 32'h0000_2000);
        rd(6'h01, rv); chk("R11 W1C clears", rv, 32'h0000_0012);

        // R8, R11: port disable flushes queue and overflow bits
        set_ready(1'b0);
        for (int i = 0; i < 8; i++) push(3'd1, 32'hE100 + 32'(i));
        push(3'd6, 32'hE1FF);
        cyc(2);
        rd(6'h01, rv); chk("R10 overflow bit tag6", rv, 32'h0000_4012);
        wr(6'h00, CTRL_NOPRT);
        cyc(2);
        push(3'd1, 32'hEEEE);
        wr(6'h00, CTRL_RUN);
        rd(6'h01, rv); chk("R11 port disable clears", rv, 32'h0000_0012);
        n0 = nlog;
        push(3'd1, 32'hE000);
        set_ready(1'b1);
        cyc(5);
        chk("R8 only new entry written", 32'(nlog - n0), 32'd1);
        chk("R8 new entry address", log_a[n0], 32'h300);
        chk("R8 new entry data", log_d[n0], 32'hE000);

        summary();
        $finish;
    end
endmodule